// File: doc/BRIEF.md
# I/O Channel Interrupt Controller

This block holds the interrupt state of one I/O channel that runs its own command program. Six check conditions come from the attached device controller and from the channel itself. Each one sets a sticky condition bit. A 6-bit enable mask selects which of these bits can raise an interrupt request. When a request is taken, the block writes the channel's command counter and address counter into a fixed save word in memory. The write uses a request/acknowledge handshake. The block then tells the command fetcher to continue from the word after the save word.

Once an interrupt is taken the channel stays in interrupt mode until it is told to leave. There are two ways out: the channel's own load-interrupt-program command, or a clear-and-exit request from the central processor. The processor can also clear only the conditions, which leaves the mode set. An I/O check or sequence check that arrives during a data transfer is held back until the device signals end of operation. A device unusual end always interrupts at once.

Top module: `chan_irq_ctrl`

## Requirements
- R1: After synchronous reset, int_mode is 0, cond is 0, the mask is 0, mem_req is 0 and redirect_valid is 0.
- R2: A 1 on cond_set[i] while int_mode is 0 sets cond[i] at the next clock edge, and the bit stays set until it is cleared. The bit map is: 0 I/O check, 1 sequence check, 2 device unusual end, 3 attention 1, 4 attention 2, 5 adapter check.
- R3: A request exists only when (cond & mask) is nonzero. The mask is loaded from mask_din when mask_we is 1, and mask bit i enables cond bit i.
- R4: A request is taken at a clock edge when int_mode is 0, trap_pend is 0, no save is in progress and no exit is requested. At that edge int_mode becomes 1 and mem_req rises with mem_addr = IL_ADDR. At the same edge mem_wdata takes cc_in in bits [14:0], ac_in in bits [32:18], and zeros in the other bits.
- R5: mem_req and its address and data stay steady until an edge where mem_ack is 1. At that edge mem_req drops. At the edge after that, redirect_valid is 1 for exactly one cycle with redirect_addr = IL_ADDR+1.
- R6: While int_mode is 1, an I/O check on cond_set[0] is discarded and does not set cond[0]. The other condition bits still latch, but they start no interrupt.
- R7: cpu_clr_cond clears all of cond and leaves int_mode unchanged.
- R8: lip_exec clears int_mode and cond[0]. cpu_clr_exit clears int_mode and all of cond.
- R9: Clears win over sets. A condition clear in the same cycle as a condition set leaves the bit 0. An exit request in a cycle where a request could be taken blocks the take in that cycle.
- R10: While trap_pend is 1, no interrupt is taken. A pending request is taken once trap_pend falls.
- R11: An I/O check or sequence check accepted while xfer_active is 1 does not request until a dev_end pulse. A device unusual end requests at once even while xfer_active is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cond_set | input | 6 | Condition set pulses, one bit per check |
| xfer_active | input | 1 | Data transfer in progress |
| dev_end | input | 1 | Device end pulse that releases deferred checks |
| mask_we | input | 1 | Load the enable mask |
| mask_din | input | 6 | New enable mask |
| trap_pend | input | 1 | Trap to processor pending; blocks taking |
| lip_exec | input | 1 | Channel load-interrupt-program command |
| cpu_clr_cond | input | 1 | Processor request: clear conditions only |
| cpu_clr_exit | input | 1 | Processor request: clear conditions and leave mode |
| cc_in | input | 15 | Current command counter |
| ac_in | input | 15 | Current address counter |
| mem_ack | input | 1 | Memory write acknowledge |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | 15 | Memory write address |
| mem_wdata | output | 36 | Memory write data |
| redirect_valid | output | 1 | One-cycle command fetch redirect |
| redirect_addr | output | 15 | New command fetch address |
| int_mode | output | 1 | Interrupt mode flag |
| cond | output | 6 | Condition register |

## Verification
The hardest cases to reach from the ports are the ones where two controls line up in one cycle. One is an exit request in the exact cycle where a pending request would otherwise be taken. The bench gets there by latching a condition while in interrupt mode and then holding lip_exec for two cycles. The first cycle drops the mode and the second blocks the take, so mem_req must stay low until lip_exec is released. The deferred I/O check is reached by raising xfer_active before the check pulse. The bench confirms that no save starts until dev_end.

// File: rtl/cic_pkg.sv
package cic_pkg;
  localparam int NCOND   = 6;
  localparam int B_IOCHK = 0;
  localparam int B_SEQCK = 1;
  localparam int B_UEND  = 2;
  localparam int B_ATN1  = 3;
  localparam int B_ATN2  = 4;
  localparam int B_ADPCK = 5;

  typedef enum logic [1:0] {
    SV_IDLE   = 2'd0,
    SV_WRITE  = 2'd1,
    SV_VECTOR = 2'd2
  } save_state_t;
endpackage

// File: rtl/cic_cond_reg.sv
module cic_cond_reg #(
  parameter int NC = 6,
  parameter logic [NC-1:0] DEFER_BITS = 6'b000011,
  parameter logic [NC-1:0] DROP_IN_MODE = 6'b000001
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NC-1:0] cond_set,
  input  logic          mode,
  input  logic          xfer_active,
  input  logic          dev_end,
  input  logic          mask_we,
  input  logic [NC-1:0] mask_din,
  input  logic          clr_all,
  input  logic          clr_io,
  output logic [NC-1:0] cond_q,
  output logic          req
);
  logic [NC-1:0] mask_q;
  logic          hold_q;
  logic [NC-1:0] accept;
  logic [NC-1:0] cond_d;
  logic [NC-1:0] gate;

  always_comb begin
    accept = mode ? (cond_set & ~DROP_IN_MODE) : cond_set;
    cond_d = cond_q | accept;
    if (clr_io) cond_d = cond_d & ~DROP_IN_MODE;
    if (clr_all) cond_d = '0;
    gate = hold_q ? ~DEFER_BITS : {NC{1'b1}};
  end

  assign req = |(cond_q & mask_q & gate);

  always_ff @(posedge clk) begin
    if (rst) begin
      cond_q <= '0;
      mask_q <= '0;
      hold_q <= 1'b0;
    end else begin
      cond_q <= cond_d;
      if (mask_we) mask_q <= mask_din;
      if (clr_all || dev_end) hold_q <= 1'b0;
      else if (xfer_active && |(accept & DEFER_BITS)) hold_q <= 1'b1;
    end
  end
endmodule

// File: rtl/cic_save_fsm.sv
module cic_save_fsm
  import cic_pkg::*;
#(
  parameter int AW = 15,
  parameter int DW = 36,
  parameter logic [AW-1:0] IL_ADDR = 15'h0040
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic [AW-1:0] cc_in,
  input  logic [AW-1:0] ac_in,
  input  logic          mem_ack,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          redirect_valid,
  output logic [AW-1:0] redirect_addr,
  output logic          idle
);
  localparam int AC_LSB = DW - AW - 3;
  localparam logic [AW-1:0] VEC_ADDR = IL_ADDR + AW'(1);

  save_state_t st_q;
  logic [DW-1:0] pack;

  always_comb begin
    pack = '0;
    pack[AW-1:0] = cc_in;
    pack[AC_LSB +: AW] = ac_in;
  end

  assign idle = (st_q == SV_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q           <= SV_IDLE;
      mem_req        <= 1'b0;
      mem_addr       <= '0;
      mem_wdata      <= '0;
      redirect_valid <= 1'b0;
      redirect_addr  <= '0;
    end else begin
      redirect_valid <= 1'b0;
      case (st_q)
        SV_IDLE: if (take) begin
          st_q      <= SV_WRITE;
          mem_req   <= 1'b1;
          mem_addr  <= IL_ADDR;
          mem_wdata <= pack;
        end
        SV_WRITE: if (mem_ack) begin
          st_q    <= SV_VECTOR;
          mem_req <= 1'b0;
        end
        SV_VECTOR: begin
          st_q           <= SV_IDLE;
          redirect_valid <= 1'b1;
          redirect_addr  <= VEC_ADDR;
        end
        default: st_q <= SV_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/chan_irq_ctrl.sv
module chan_irq_ctrl
  import cic_pkg::*;
#(
  parameter int AW = 15,
  parameter int DW = 36,
  parameter logic [AW-1:0] IL_ADDR = 15'h0040
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NCOND-1:0] cond_set,
  input  logic             xfer_active,
  input  logic             dev_end,
  input  logic             mask_we,
  input  logic [NCOND-1:0] mask_din,
  input  logic             trap_pend,
  input  logic             lip_exec,
  input  logic             cpu_clr_cond,
  input  logic             cpu_clr_exit,
  input  logic [AW-1:0]    cc_in,
  input  logic [AW-1:0]    ac_in,
  input  logic             mem_ack,
  output logic             mem_req,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  output logic             redirect_valid,
  output logic [AW-1:0]    redirect_addr,
  output logic             int_mode,
  output logic [NCOND-1:0] cond
);
  localparam logic [NCOND-1:0] DEFER = NCOND'((1 << B_IOCHK) | (1 << B_SEQCK));
  localparam logic [NCOND-1:0] DROP  = NCOND'(1 << B_IOCHK);

  logic req, idle, take, exit_any;

  assign exit_any = lip_exec | cpu_clr_exit;
  assign take = req & ~int_mode & ~trap_pend & idle & ~exit_any;

  cic_cond_reg #(.NC(NCOND), .DEFER_BITS(DEFER), .DROP_IN_MODE(DROP)) u_cond (
    .clk(clk), .rst(rst), .cond_set(cond_set), .mode(int_mode),
    .xfer_active(xfer_active), .dev_end(dev_end),
    .mask_we(mask_we), .mask_din(mask_din),
    .clr_all(cpu_clr_cond | cpu_clr_exit), .clr_io(lip_exec),
    .cond_q(cond), .req(req)
  );

  cic_save_fsm #(.AW(AW), .DW(DW), .IL_ADDR(IL_ADDR)) u_save (
    .clk(clk), .rst(rst), .take(take), .cc_in(cc_in), .ac_in(ac_in),
    .mem_ack(mem_ack), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .redirect_valid(redirect_valid),
    .redirect_addr(redirect_addr), .idle(idle)
  );

  always_ff @(posedge clk) begin
    if (rst) int_mode <= 1'b0;
    else if (exit_any) int_mode <= 1'b0;
    else if (take) int_mode <= 1'b1;
  end
endmodule

// File: rtl/chan_irq_ctrl_chk.sv
module chan_irq_ctrl_chk #(
  parameter int AW = 15,
  parameter int DW = 36
) (
  input logic          clk,
  input logic          rst,
  input logic [5:0]    cond_set,
  input logic          trap_pend,
  input logic          lip_exec,
  input logic          cpu_clr_cond,
  input logic          cpu_clr_exit,
  input logic          mem_ack,
  input logic          mem_req,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          redirect_valid,
  input logic          int_mode,
  input logic [5:0]    cond
);
  a_r5_req_held: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_wdata));
  a_r5_redirect_after_ack: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_ack |=> !mem_req ##1 redirect_valid);
  a_r5_redirect_alone: assert property (@(posedge clk) disable iff (rst)
    redirect_valid |-> !mem_req);
  a_r4_take_sets_mode: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req) |-> int_mode);
  a_r6_io_dropped: assert property (@(posedge clk) disable iff (rst)
    int_mode && !cond[0] && !lip_exec && !cpu_clr_exit |=> !cond[0]);
  a_r7_clear_keeps_mode: assert property (@(posedge clk) disable iff (rst)
    cpu_clr_cond && int_mode && !lip_exec && !cpu_clr_exit |=> int_mode && cond == 6'b0);
  a_r10_trap_blocks: assert property (@(posedge clk) disable iff (rst)
    trap_pend && !mem_req |=> !mem_req);
  a_r9_exit_blocks_take: assert property (@(posedge clk) disable iff (rst)
    (lip_exec || cpu_clr_exit) && !mem_req |=> !mem_req && !int_mode);
endmodule

bind chan_irq_ctrl chan_irq_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .cond_set(cond_set), .trap_pend(trap_pend),
  .lip_exec(lip_exec), .cpu_clr_cond(cpu_clr_cond), .cpu_clr_exit(cpu_clr_exit),
  .mem_ack(mem_ack), .mem_req(mem_req), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .redirect_valid(redirect_valid),
  .int_mode(int_mode), .cond(cond)
);

// File: tb/chan_irq_ctrl_test.sv
`timescale 1ns/1ps
module chan_irq_ctrl_test;
  localparam logic [14:0] IL = 15'h0040;

  logic clk = 0, rst = 1;
  logic [5:0] cond_set = 0, mask_din = 0;
  logic xfer_active = 0, dev_end = 0, mask_we = 0, trap_pend = 0;
  logic lip_exec = 0, cpu_clr_cond = 0, cpu_clr_exit = 0, mem_ack = 0;
  logic [14:0] cc_in = 0, ac_in = 0;
  logic mem_req, redirect_valid, int_mode;
  logic [14:0] mem_addr, redirect_addr;
  logic [35:0] mem_wdata;
  logic [5:0] cond;

  int tests = 0, fails = 0, saves = 0, ack_cnt = 0;
  logic req_seen = 0, done = 0;

  typedef struct { bit is_write; logic [14:0] addr; logic [35:0] data; } sb_item_t;
  sb_item_t sbq[$];

  always #2.5 clk = ~clk;

  chan_irq_ctrl uut (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_save(input logic [14:0] cc, input logic [14:0] ac);
    sb_item_t w, r;
    w.is_write = 1; w.addr = IL; w.data = 36'(cc) | (36'(ac) << 18);
    r.is_write = 0; r.addr = IL + 15'd1; r.data = '0;
    sbq.push_back(w);
    sbq.push_back(r);
  endtask

  task automatic drain(input string req);
    for (int i = 0; i < 20 && sbq.size() != 0; i++) tick();
    chk(sbq.size() == 0, req, sbq.size(), 0);
  endtask

  task automatic pulse_cond(input logic [5:0] v);
    cond_set = v; tick(); cond_set = 0;
  endtask

  // monitor and acknowledge responder, both on the falling edge
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_req && !req_seen) begin
        saves++;
        if (sbq.size() == 0 || !sbq[0].is_write)
          chk(0, "R4 unexpected write", mem_addr, 0);
        else begin
          chk(mem_addr == sbq[0].addr, "R4 write addr", mem_addr, sbq[0].addr);
          chk(mem_wdata == sbq[0].data, "R4 write data", mem_wdata, sbq[0].data);
          void'(sbq.pop_front());
        end
      end
      if (redirect_valid) begin
        if (sbq.size() == 0 || sbq[0].is_write)
          chk(0, "R5 unexpected redirect", redirect_addr, 0);
        else begin
          chk(redirect_addr == sbq[0].addr, "R5 redirect addr", redirect_addr, sbq[0].addr);
          void'(sbq.pop_front());
        end
      end
      req_seen = mem_req;
      if (mem_req && !mem_ack) begin
        ack_cnt++;
        if (ack_cnt >= 2) mem_ack = 1;
      end else begin
        mem_ack = 0;
        ack_cnt = 0;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int s0;
    tick(3); rst = 0; tick();
    // R1 reset state
    chk(int_mode == 0 && cond == 0, "R1 mode/cond", {int_mode, cond}, 0);
    chk(!mem_req && !redirect_valid, "R1 req/redirect", {mem_req, redirect_valid}, 0);

    // R2/R3: latch with mask closed, no request
    cc_in = 15'h1234; ac_in = 15'h0abc;
    s0 = saves;
    pulse_cond(6'b001000);
    chk(cond == 6'b001000, "R2 latch attn1", cond, 6'b001000);
    tick(4);
    chk(saves == s0 && cond == 6'b001000, "R3 masked no save", saves - s0, 0);

    // R3/R4/R5: open mask bit 3 -> save
    expect_save(15'h1234, 15'h0abc);
    mask_din = 6'b001000; mask_we = 1; tick(); mask_we = 0;
    drain("R5 save completes");
    chk(int_mode == 1, "R4 mode set", int_mode, 1);

    // R6: in mode io check dropped, seq check latched, no new save
    s0 = saves;
    mask_din = 6'b111111; mask_we = 1; tick(); mask_we = 0;
    pulse_cond(6'b000011);
    tick(3);
    chk(cond == 6'b001010, "R6 io dropped", cond, 6'b001010);
    chk(saves == s0, "R6 no save in mode", saves - s0, 0);

    // R7: clear conditions keeps mode
    cpu_clr_cond = 1; tick(); cpu_clr_cond = 0;
    chk(cond == 0 && int_mode == 1, "R7 clr keeps mode", {int_mode, cond}, 7'h40);

    // R9: clear beats set in same cycle
    cond_set = 6'b010000; cpu_clr_cond = 1; tick(); cond_set = 0; cpu_clr_cond = 0;
    chk(cond == 0, "R9 clear wins", cond, 0);

    // R8: lip exits mode
    lip_exec = 1; tick(); lip_exec = 0;
    chk(int_mode == 0, "R8 lip exits", int_mode, 0);

    // R10: trap pending blocks take
    trap_pend = 1; s0 = saves;
    cc_in = 15'h7001; ac_in = 15'h0002;
    pulse_cond(6'b100000);
    tick(4);
    chk(saves == s0 && !mem_req, "R10 trap blocks", saves - s0, 0);
    expect_save(15'h7001, 15'h0002);
    trap_pend = 0;
    drain("R10 taken after trap");

    // R9: exit held two cycles blocks the take; attn2 latched in mode
    pulse_cond(6'b010000);
    chk(cond == 6'b110000, "R2 latch in mode", cond, 6'b110000);
    cc_in = 15'h0555; ac_in = 15'h2aaa;
    cpu_clr_cond = 0;
    lip_exec = 1; tick(2);
    chk(!mem_req && int_mode == 0, "R9 exit blocks take", {mem_req, int_mode}, 0);
    expect_save(15'h0555, 15'h2aaa);
    lip_exec = 0; tick();
    chk(mem_req == 1 && int_mode == 1, "R9 take after exit", {mem_req, int_mode}, 3);
    drain("R9 save completes");

    // R8: processor exit clears everything
    cpu_clr_exit = 1; tick(); cpu_clr_exit = 0;
    chk(int_mode == 0 && cond == 0, "R8 cpu exit", {int_mode, cond}, 0);

    // R11: io check during transfer deferred to dev_end
    xfer_active = 1; s0 = saves;
    cc_in = 15'h0101; ac_in = 15'h0202;
    pulse_cond(6'b000001);
    tick(4);
    chk(cond == 6'b000001 && saves == s0, "R11 deferred", saves - s0, 0);
    expect_save(15'h0101, 15'h0202);
    dev_end = 1; tick(); dev_end = 0;
    drain("R11 released by dev_end");
    cpu_clr_exit = 1; tick(); cpu_clr_exit = 0;

    // R11: unusual end immediate during transfer
    cc_in = 15'h3333; ac_in = 15'h4444;
    expect_save(15'h3333, 15'h4444);
    pulse_cond(6'b000100);
    tick();
    chk(mem_req == 1, "R11 unusual end immediate", mem_req, 1);
    drain("R11 unusual end save");
    xfer_active = 0;

    tick(2);
    chk(sbq.size() == 0, "R5 scoreboard empty", sbq.size(), 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule